// File: doc/BRIEF.md
# Microcode Store Load and Readback Port

This block sits between a host I/O bus and a 1024-word, 24-bit writable microcode store held in an internal register array. The host addresses it with a device select code and a set of single-cycle strobes. These are control set/clear, flag set/clear, two 16-bit output strobes (A and B), two input strobes (A and B) and a preset. Each stored word has an 8-bit upper field and a 16-bit lower field.

The port has two modes. In command mode, output A loads the RAM address counter and output B picks the control-memory module the store answers for. In data mode, the A strobes move the upper byte and the B strobes move the lower 16 bits of the word at the counter, and the counter advances after each B transfer. A separate enable flag lets the microsequencer fetch from the store. When the flag is set and the sequencer asks for the selected module, the store claims the fetch ahead of built-in microcode.

Top module: `wcs_host_port`

## Requirements
- R1: After reset the port is in command mode, the address counter is 0, the module register is 0 and `store_en` is 0.
- R2: A `ctl_set` strobe with the own select code enters data mode. A `ctl_clr` strobe with the own select code enters command mode. A clear wins if both arrive together.
- R3: In command mode, `out_a` loads the address counter from `bus_wdata[9:0]`. `out_b` loads the module register from `bus_wdata` only when the value is 2 to 5; any other value leaves the module register unchanged.
- R4: In data mode, `out_a` writes `bus_wdata[7:0]` to the upper field of the word at the counter. `out_b` writes `bus_wdata[15:0]` to its lower field and then adds one to the counter.
- R5: In data mode, `in_a` drives `bus_rdata` with the upper field in bits 7:0 and zeros in bits 15:8. `in_b` drives the lower field and then adds one to the counter. `bus_rdata` is valid while the strobe is high.
- R6: In command mode, `in_a` and `in_b` return 0 and leave the address counter unchanged.
- R7: In command mode, output strobes change no stored word.
- R8: The counter wraps from 1023 to 0, so continued data-mode writes land at address 0 again.
- R9: `preset`, or `ctl_clr` with select code 0, forces command mode whatever select code the port has.
- R10: Strobes carrying a select code other than the port's own change neither the mode, the counter, the store nor the enable flag, and input strobes return 0.
- R11: `flg_set` with the own code sets `store_en` and `flg_clr` clears it. `seq_claim` is high exactly when `store_en` is high and `seq_module` equals the module register. `seq_word` is the word at `seq_addr`, upper field in bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 6 | Select code of the current I/O strobe |
| ctl_set | input | 1 | Set-control strobe (data mode) |
| ctl_clr | input | 1 | Clear-control strobe (command mode) |
| flg_set | input | 1 | Set-flag strobe (enable store) |
| flg_clr | input | 1 | Clear-flag strobe (disable store) |
| out_a | input | 1 | Output strobe A |
| out_b | input | 1 | Output strobe B |
| in_a | input | 1 | Input strobe A |
| in_b | input | 1 | Input strobe B |
| preset | input | 1 | Bus preset, forces command mode |
| bus_wdata | input | 16 | Host output word |
| bus_rdata | output | 16 | Host input word, valid during an input strobe |
| store_en | output | 1 | Store enabled for microcode execution |
| seq_module | input | 3 | Module requested by the microsequencer |
| seq_addr | input | 10 | Fetch address from the microsequencer |
| seq_word | output | 24 | Microword at seq_addr |
| seq_claim | output | 1 | Store takes this fetch over built-in microcode |

## Verification
The counter and the mode flip-flop are hidden, so a fault in either shows at the ports only through later data traffic. A counter that slips or steps in command mode makes the next data-mode read return the neighbouring word, on the first word read back after the fault. A stuck mode bit makes a command-mode input return stored data instead of zero, in the same cycle as the strobe. A wrong module register or enable flag shows on `seq_claim` one cycle after the strobe that set it.

// File: rtl/wcs_host_port.sv
module wcs_host_port #(
  parameter logic [5:0] SELECT_CODE = 6'd20,
  parameter int ADDR_W  = 10,
  parameter int HI_W    = 8,
  parameter int LO_W    = 16,
  parameter int BUS_W   = 16,
  parameter int MOD_W   = 3,
  parameter int MOD_MIN = 2,
  parameter int MOD_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        bus_sel,
  input  logic              ctl_set,
  input  logic              ctl_clr,
  input  logic              flg_set,
  input  logic              flg_clr,
  input  logic              out_a,
  input  logic              out_b,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              preset,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              store_en,
  input  logic [2:0]        seq_module,
  input  logic [9:0]        seq_addr,
  output logic [23:0]       seq_word,
  output logic              seq_claim
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [HI_W-1:0]   hi_mem [DEPTH];
  logic [LO_W-1:0]   lo_mem [DEPTH];
  logic              data_mode;
  logic [ADDR_W-1:0] addr_q;
  logic [MOD_W-1:0]  mod_q;

  wire hit     = (bus_sel == SELECT_CODE);
  wire go_cmd  = preset | (ctl_clr & (hit | bus_sel == 6'd0));
  wire go_data = hit & ctl_set;
  wire wr_hi   = hit & out_a & data_mode;
  wire wr_lo   = hit & out_b & data_mode;
  wire step    = wr_lo | (hit & in_b & data_mode);
  wire mod_ok  = (int'(bus_wdata) >= MOD_MIN) && (int'(bus_wdata) <= MOD_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_mode <= 1'b0;
      addr_q    <= '0;
      mod_q     <= '0;
      store_en  <= 1'b0;
    end else begin
      if (go_cmd)       data_mode <= 1'b0;
      else if (go_data) data_mode <= 1'b1;

      if (hit & out_a & !data_mode) addr_q <= bus_wdata[ADDR_W-1:0];
      else if (step)                addr_q <= addr_q + 1'b1;

      if (hit & out_b & !data_mode & mod_ok) mod_q <= bus_wdata[MOD_W-1:0];

      if (hit & flg_clr)      store_en <= 1'b0;
      else if (hit & flg_set) store_en <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hi) hi_mem[addr_q] <= bus_wdata[HI_W-1:0];
    if (wr_lo) lo_mem[addr_q] <= bus_wdata[LO_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit & data_mode) begin
      if (in_a)      bus_rdata = BUS_W'(hi_mem[addr_q]);
      else if (in_b) bus_rdata = BUS_W'(lo_mem[addr_q]);
    end
  end

  assign seq_word  = {hi_mem[seq_addr], lo_mem[seq_addr]};
  assign seq_claim = store_en && (seq_module == mod_q);
endmodule

// File: rtl/wcs_host_port_chk.sv
module wcs_host_port_chk #(
  parameter logic [5:0] SELECT_CODE = 6'd20,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        bus_sel,
  input logic              ctl_clr,
  input logic              flg_set,
  input logic              flg_clr,
  input logic              out_a,
  input logic              out_b,
  input logic              in_b,
  input logic              preset,
  input logic              data_mode,
  input logic [ADDR_W-1:0] addr_q,
  input logic              store_en
);
  wire hit = (bus_sel == SELECT_CODE);

  assert_cmd_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_mode && !out_a) |=> $stable(addr_q));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && data_mode && out_b && !out_a) |=> addr_q == ADDR_W'($past(addr_q) + 1));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && data_mode && (out_b || in_b) && !out_a && addr_q == '1) |=> addr_q == '0);

  assert_force_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (preset || (ctl_clr && bus_sel == 6'd0)) |=> !data_mode);

  assert_foreign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && bus_sel != 6'd0 && !preset) |=>
      ($stable(data_mode) && $stable(addr_q) && $stable(store_en)));

  assert_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && flg_set && !flg_clr) |=> store_en);
endmodule

bind wcs_host_port wcs_host_port_chk #(.SELECT_CODE(SELECT_CODE), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .ctl_clr(ctl_clr),
  .flg_set(flg_set), .flg_clr(flg_clr), .out_a(out_a), .out_b(out_b),
  .in_b(in_b), .preset(preset), .data_mode(data_mode), .addr_q(addr_q),
  .store_en(store_en)
);

// File: tb/sim_wcs_host_port.sv
module sim_wcs_host_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] OWN   = 6'd20;
  localparam logic [5:0] OTHER = 6'd21;
  localparam int K_CSET = 0, K_CCLR = 1, K_FSET = 2, K_FCLR = 3,
                 K_OA = 4, K_OB = 5, K_IA = 6, K_IB = 7, K_PRE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] bus_sel = '0;
  logic ctl_set = 0, ctl_clr = 0, flg_set = 0, flg_clr = 0;
  logic out_a = 0, out_b = 0, in_a = 0, in_b = 0, preset = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic store_en, seq_claim;
  logic [2:0] seq_module = '0;
  logic [9:0] seq_addr = '0;
  logic [23:0] seq_word;
  int n_chk = 0, n_bad = 0;
  logic [15:0] r, h, l;

  wcs_host_port #(.SELECT_CODE(OWN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
    .flg_set(flg_set), .flg_clr(flg_clr), .out_a(out_a), .out_b(out_b), .in_a(in_a),
    .in_b(in_b), .preset(preset), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .store_en(store_en), .seq_module(seq_module), .seq_addr(seq_addr),
    .seq_word(seq_word), .seq_claim(seq_claim));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic [5:0] sel, input int kind, input logic [15:0] d, output logic [15:0] rd);
    bus_sel = sel; bus_wdata = d;
    case (kind)
      K_CSET: ctl_set = 1; K_CCLR: ctl_clr = 1; K_FSET: flg_set = 1; K_FCLR: flg_clr = 1;
      K_OA: out_a = 1; K_OB: out_b = 1; K_IA: in_a = 1; K_IB: in_b = 1;
      default: preset = 1;
    endcase
    #(CLK_PERIOD/4);
    rd = bus_rdata;
    @(negedge clk);
    {ctl_set, ctl_clr, flg_set, flg_clr, out_a, out_b, in_a, in_b, preset} = '0;
    bus_sel = '0;
  endtask

  task automatic go(input logic [5:0] sel, input int kind, input logic [15:0] d);
    logic [15:0] dummy;
    op(sel, kind, d, dummy);
  endtask

  task automatic set_addr(input logic [9:0] a);
    go(OWN, K_CCLR, 0);
    go(OWN, K_OA, {6'd0, a});
  endtask

  task automatic put(input logic [15:0] hi, input logic [15:0] lo);
    go(OWN, K_OA, hi);
    go(OWN, K_OB, lo);
  endtask

  task automatic get(output logic [15:0] hi, output logic [15:0] lo);
    op(OWN, K_IA, 0, hi);
    op(OWN, K_IB, 0, lo);
  endtask

  task automatic t_reset;
    chk("R1", "store_en", store_en, 0);
    seq_module = 3'd0; #1;
    chk("R1", "claim with module 0", seq_claim, 0);
    op(OWN, K_IA, 0, r);
    chk("R1", "command-mode read", r, 0);
    go(OWN, K_CSET, 0);
    put(16'h003C, 16'hBEEF);
    set_addr(0);
    go(OWN, K_CSET, 0);
    get(h, l);
    chk("R1", "first write landed at 0 hi", h, 16'h003C);
    chk("R2", "data mode lo", l, 16'hBEEF);
  endtask

  task automatic t_rw;
    set_addr(5);
    go(OWN, K_CSET, 0);
    put(16'hFF5A, 16'h1111);
    put(16'h00A5, 16'h2222);
    put(16'h0081, 16'h3333);
    set_addr(5);
    go(OWN, K_CSET, 0);
    get(h, l);
    chk("R5", "hi byte zero-extended", h, 16'h005A);
    chk("R4", "lo word 5", l, 16'h1111);
    get(h, l);
    chk("R4", "hi word 6", h, 16'h00A5);
    chk("R5", "lo word 6", l, 16'h2222);
    get(h, l);
    chk("R4", "word 7", {h, l}, {16'h0081, 16'h3333});
  endtask

  task automatic t_cmd_inputs;
    set_addr(100);
    go(OWN, K_CSET, 0);
    put(16'h0042, 16'hCAFE);
    set_addr(100);
    for (int i = 0; i < 3; i++) begin
      op(OWN, K_IA, 0, r); chk("R6", "cmd in_a zero", r, 0);
      op(OWN, K_IB, 0, r); chk("R6", "cmd in_b zero", r, 0);
    end
    go(OWN, K_CSET, 0);
    get(h, l);
    chk("R6", "counter not advanced", {h, l}, {16'h0042, 16'hCAFE});
  endtask

  task automatic t_cmd_outputs;
    set_addr(200);
    go(OWN, K_CSET, 0);
    put(16'h0099, 16'h5555);
    go(OWN, K_CCLR, 0);
    go(OWN, K_OA, 16'd200);
    go(OWN, K_OB, 16'd4);
    go(OWN, K_OA, 16'd200);
    go(OWN, K_CSET, 0);
    get(h, l);
    chk("R7", "word survives command outputs", {h, l}, {16'h0099, 16'h5555});
  endtask

  task automatic t_module;
    go(OWN, K_CCLR, 0);
    go(OWN, K_OB, 16'd3);
    go(OWN, K_FSET, 0);
    chk("R11", "enable set", store_en, 1);
    seq_module = 3'd3; seq_addr = 10'd5; #1;
    chk("R3", "claim for module 3", seq_claim, 1);
    chk("R11", "fetch word at 5", seq_word, 24'h5A1111);
    seq_module = 3'd2; #1;
    chk("R11", "no claim other module", seq_claim, 0);
    go(OWN, K_OB, 16'd7);
    seq_module = 3'd3; #1;
    chk("R3", "illegal module 7 ignored", seq_claim, 1);
    go(OWN, K_OB, 16'd5);
    seq_module = 3'd5; #1;
    chk("R3", "module 5 accepted", seq_claim, 1);
    go(OWN, K_FCLR, 0);
    chk("R11", "enable cleared", store_en, 0);
    #1;
    chk("R11", "no claim when disabled", seq_claim, 0);
  endtask

  task automatic t_wrap;
    set_addr(1023);
    go(OWN, K_CSET, 0);
    put(16'h0011, 16'hAAAA);
    put(16'h0022, 16'hBBBB);
    set_addr(1023);
    go(OWN, K_CSET, 0);
    get(h, l);
    chk("R8", "word 1023", {h, l}, {16'h0011, 16'hAAAA});
    get(h, l);
    chk("R8", "wrapped write at 0", {h, l}, {16'h0022, 16'hBBBB});
  endtask

  task automatic t_preset;
    set_addr(300);
    go(OWN, K_CSET, 0);
    put(16'h0077, 16'h1234);
    set_addr(300);
    go(OWN, K_CSET, 0);
    go(OWN, K_PRE, 0);
    op(OWN, K_IA, 0, r);
    chk("R9", "preset gives command mode", r, 0);
    go(OWN, K_CSET, 0);
    op(OWN, K_IA, 0, r);
    chk("R2", "back in data mode", r, 16'h0077);
    go(6'd0, K_CCLR, 0);
    op(OWN, K_IA, 0, r);
    chk("R9", "select 0 clear gives command mode", r, 0);
  endtask

  task automatic t_foreign;
    set_addr(400);
    go(OWN, K_CSET, 0);
    put(16'h00C3, 16'h0F0F);
    set_addr(400);
    go(OTHER, K_CSET, 0);
    op(OWN, K_IA, 0, r);
    chk("R10", "foreign ctl_set ignored", r, 0);
    go(OWN, K_CSET, 0);
    go(OTHER, K_OA, 16'h00FF);
    go(OTHER, K_OB, 16'hFFFF);
    op(OTHER, K_IA, 0, r);
    chk("R10", "foreign in_a returns 0", r, 0);
    op(OTHER, K_IB, 0, r);
    chk("R10", "foreign in_b returns 0", r, 0);
    go(OTHER, K_CCLR, 0);
    get(h, l);
    chk("R10", "word and counter untouched", {h, l}, {16'h00C3, 16'h0F0F});
    go(OTHER, K_FSET, 0);
    chk("R10", "foreign flg_set ignored", store_en, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rw;
    t_cmd_inputs;
    t_cmd_outputs;
    t_module;
    t_wrap;
    t_preset;
    t_foreign;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule